// File: doc/BRIEF.md
# NFC Controller Power State Controller

This block decides which power state an NFC controller is in and which internal supply domains are switched on. It tracks six observable states: hard power-down, battery monitor, standby, and the three active sub-modes idle, listener and poller. A short boot phase sits between the off states and idle. The external enable pin always wins. After it, an undervoltage monitor with hysteresis takes priority. Below both, the discovery sequencer steers the block between the active sub-modes and standby.

The analog side is reduced to digital flags. The battery comparator is read through two flags, one per threshold of the hysteresis band. Two supply flags report whether the supply is at least 2.3 V or at least 2.7 V. Three wake events can bring the block out of standby: a host bus address match, an RF field detection and expiry of the wake timer. The wake timer counts only while the low-frequency oscillator runs. The event that caused a wake is kept in a sticky register until the host acknowledges it.

State codes on `state_code`: 0 hard power-down, 1 monitor, 2 standby, 3 idle, 4 listener, 5 poller, 6 boot.

Top module: `nfc_pwr_ctrl`

## Requirements
- R1: During and directly after reset, `state_code` is 0, `cpu_pwr_en`, `rf_pwr_en` and `wkdet_pwr_en` are low, and `wake_src` is 0.
- R2: When `en_pin` is low at a clock edge, `state_code` is 0 after that edge, whatever the state and the other inputs are. It stays 0 as long as `en_pin` stays low.
- R3: With `mon_en` high, the block enters monitor (code 1) when `bat_ok_fall` is low. It stays there while `bat_ok_rise` is low, even if `bat_ok_fall` has returned high. It moves to boot (code 6) once `bat_ok_rise` is high. With `mon_en` low, a low battery has no effect.
- R4: Leaving hard power-down or monitor enters boot (code 6). The block stays in boot for exactly BOOT_CYCLES clock edges and then reports idle (code 3).
- R5: Standby (code 2) switches off both the CPU domain and the RF domain, and switches on only the wake detector domain (`wkdet_pwr_en`).
- R6: The block enters standby from an active sub-mode only when `req_sleep` and `stby_en` are both high. When `stby_en` is low, a sleep request leaves it in idle.
- R7: In an active sub-mode, `req_listen` with `sup_2v3` high selects listener (code 4) at the next edge.
- R8: In an active sub-mode, `req_poll` with `sup_2v7` high selects poller (code 5), and this takes priority over listener. Without `sup_2v7` the poll request is refused, and a poller whose `sup_2v7` drops falls back at the next edge.
- R9: In standby, `wk_host` or `wk_field` returns the block to idle at the next edge. `wk_timer` does the same when `lfo_on` is high.
- R10: In standby, `wk_timer` has no effect while `lfo_on` is low. The state remains 2 and `wake_src` stays unchanged.
- R11: `wake_src` bit 0 (host), bit 1 (field) and bit 2 (timer) are set by a qualified wake event in standby. They stay set until `wake_ack` is high at an edge, which clears them. A new event in the same cycle as an acknowledge leaves its bit set.
- R12: `listen_ok` equals `sup_2v3` and `poll_ok` equals `sup_2v7` while an active sub-mode (codes 3 to 5) is reported; otherwise both are low. `cpu_pwr_en` is high in boot and in the active sub-modes. `rf_pwr_en` is high only in listener and poller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin | input | 1 | Enable pin level from the host (already synchronized) |
| mon_en | input | 1 | Battery monitor state enabled |
| bat_ok_rise | input | 1 | Battery above the upper (recovery) critical threshold |
| bat_ok_fall | input | 1 | Battery above the lower (entry) critical threshold |
| stby_en | input | 1 | Host permits autonomous standby |
| req_sleep | input | 1 | Sequencer requests standby |
| req_listen | input | 1 | Sequencer requests listener sub-mode |
| req_poll | input | 1 | Sequencer requests poller sub-mode |
| wk_host | input | 1 | Host bus address match |
| wk_field | input | 1 | RF level detector fired |
| wk_timer | input | 1 | Wake timer expired |
| lfo_on | input | 1 | Low-frequency oscillator running |
| wake_ack | input | 1 | Host acknowledge strobe for the wake source register |
| sup_2v3 | input | 1 | Supply at or above 2.3 V |
| sup_2v7 | input | 1 | Supply at or above 2.7 V |
| state_code | output | 3 | Current state code |
| cpu_pwr_en | output | 1 | CPU domain supply enable |
| rf_pwr_en | output | 1 | RF front-end domain supply enable |
| wkdet_pwr_en | output | 1 | Wake detector domain supply enable |
| listen_ok | output | 1 | Listener sub-mode allowed by supply |
| poll_ok | output | 1 | Poller sub-mode allowed by supply |
| wake_src | output | 3 | Sticky wake source bits |

## Verification
Every state change is registered once, so a new `state_code` and the domain enables that follow from it are due one edge after the inputs that cause it. The exception is boot, which ends exactly BOOT_CYCLES edges after it starts. `wake_src` is updated at the same edge as the wake transition. `listen_ok` and `poll_ok` follow the supply flags within the same cycle. The bench drives inputs on the falling edge and samples one falling edge later, which sees exactly one rising edge. The boot check counts edges one by one so that an early or late exit is caught. The combinational flags are sampled a moment after the inputs settle, before the next rising edge.

// File: rtl/nfc_pwr_pkg.sv
// Package: state codes and wake-source bit positions shared by the power
// state controller, its sub-blocks and its checker.
package nfc_pwr_pkg;

    // Externally visible state code; values are decoded by the host.
    typedef enum logic [2:0] {
        PS_OFF  = 3'd0,
        PS_MON  = 3'd1,
        PS_STBY = 3'd2,
        PS_IDLE = 3'd3,
        PS_LSTN = 3'd4,
        PS_POLL = 3'd5,
        PS_BOOT = 3'd6
    } pwr_state_e;

    localparam int WAKE_W   = 3;
    localparam int WK_HOST  = 0;
    localparam int WK_FIELD = 1;
    localparam int WK_TIMER = 2;

    // True for the three active sub-modes.
    function automatic logic is_active(input pwr_state_e s);
        return (s == PS_IDLE) || (s == PS_LSTN) || (s == PS_POLL);
    endfunction

endpackage

// File: rtl/nfc_pwr_boot_timer.sv
// Boot timer: counts clock edges while the boot state is held and flags the
// last boot cycle. Assumes BOOT_CYCLES >= 1; the count restarts whenever the
// run input drops.
module nfc_pwr_boot_timer #(
    parameter int BOOT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (BOOT_CYCLES > 1) ? $clog2(BOOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BOOT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count cycles spent in boot; clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The final boot cycle is reached.
    always_comb begin
        done = run && (cnt == LAST);
    end
endmodule

// File: rtl/nfc_pwr_wake_latch.sv
// Wake latch: qualifies the standby wake events (the timer only with the
// low-frequency oscillator running) and keeps the source in a sticky
// register until the host acknowledges. A set in the acknowledge cycle wins.
module nfc_pwr_wake_latch
    import nfc_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              host_hit,
    input  logic              field_hit,
    input  logic              timer_hit,
    input  logic              lfo_on,
    input  logic              ack,
    output logic              any_wake,
    output logic [WAKE_W-1:0] src
);
    logic [WAKE_W-1:0] raw;
    logic [WAKE_W-1:0] hit;

    // Gather raw events at their fixed bit positions.
    always_comb begin
        raw           = '0;
        raw[WK_HOST]  = host_hit;
        raw[WK_FIELD] = field_hit;
        raw[WK_TIMER] = timer_hit & lfo_on;
    end

    // Only events seen while armed (in standby) count.
    for (genvar b = 0; b < WAKE_W; b++) begin : g_qual
        assign hit[b] = raw[b] & armed;
    end

    assign any_wake = |hit;

    // Sticky capture with acknowledge clear; new events override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
        end else begin
            src <= hit | (src & ~{WAKE_W{ack}});
        end
    end
endmodule

// File: rtl/nfc_pwr_mode_pick.sv
// Mode picker: chooses the next state from inside the active sub-modes.
// Poller needs the 2.7 V flag and outranks listener, which needs the 2.3 V
// flag; standby needs both the request and the host permission.
module nfc_pwr_mode_pick
    import nfc_pwr_pkg::*;
(
    input  logic       req_sleep,
    input  logic       req_listen,
    input  logic       req_poll,
    input  logic       stby_en,
    input  logic       sup_2v3,
    input  logic       sup_2v7,
    output pwr_state_e pick
);
    // Priority: poller, listener, standby, idle.
    always_comb begin
        if (req_poll && sup_2v7) begin
            pick = PS_POLL;
        end else if (req_listen && sup_2v3) begin
            pick = PS_LSTN;
        end else if (req_sleep && stby_en) begin
            pick = PS_STBY;
        end else begin
            pick = PS_IDLE;
        end
    end
endmodule

// File: rtl/nfc_pwr_domain_map.sv
// Domain map: turns the current state into supply-domain enables and the
// supply-based mode-allowed flags. Purely combinational.
module nfc_pwr_domain_map
    import nfc_pwr_pkg::*;
(
    input  pwr_state_e st,
    input  logic       sup_2v3,
    input  logic       sup_2v7,
    output logic       cpu_pwr_en,
    output logic       rf_pwr_en,
    output logic       wkdet_pwr_en,
    output logic       listen_ok,
    output logic       poll_ok
);
    logic act;

    // Decode domain enables and mode permissions from the state.
    always_comb begin
        act          = is_active(st);
        cpu_pwr_en   = act || (st == PS_BOOT);
        rf_pwr_en    = (st == PS_LSTN) || (st == PS_POLL);
        wkdet_pwr_en = (st == PS_STBY);
        listen_ok    = act && sup_2v3;
        poll_ok      = act && sup_2v7;
    end
endmodule

// File: rtl/nfc_pwr_ctrl.sv
// Power state controller top: holds the state register and applies the
// priority order enable pin, battery monitor, then per-state rules.
// Assumes all inputs are synchronous to clk.
module nfc_pwr_ctrl
    import nfc_pwr_pkg::*;
#(
    parameter int BOOT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       mon_en,
    input  logic       bat_ok_rise,
    input  logic       bat_ok_fall,
    input  logic       stby_en,
    input  logic       req_sleep,
    input  logic       req_listen,
    input  logic       req_poll,
    input  logic       wk_host,
    input  logic       wk_field,
    input  logic       wk_timer,
    input  logic       lfo_on,
    input  logic       wake_ack,
    input  logic       sup_2v3,
    input  logic       sup_2v7,
    output logic [2:0] state_code,
    output logic       cpu_pwr_en,
    output logic       rf_pwr_en,
    output logic       wkdet_pwr_en,
    output logic       listen_ok,
    output logic       poll_ok,
    output logic [2:0] wake_src
);
    pwr_state_e st, nxt, pick;
    logic       boot_done;
    logic       any_wake;
    logic       bat_low;

    nfc_pwr_boot_timer #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st == PS_BOOT),
        .done  (boot_done)
    );

    nfc_pwr_wake_latch u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (st == PS_STBY),
        .host_hit  (wk_host),
        .field_hit (wk_field),
        .timer_hit (wk_timer),
        .lfo_on    (lfo_on),
        .ack       (wake_ack),
        .any_wake  (any_wake),
        .src       (wake_src)
    );

    nfc_pwr_mode_pick u_pick (
        .req_sleep  (req_sleep),
        .req_listen (req_listen),
        .req_poll   (req_poll),
        .stby_en    (stby_en),
        .sup_2v3    (sup_2v3),
        .sup_2v7    (sup_2v7),
        .pick       (pick)
    );

    nfc_pwr_domain_map u_map (
        .st           (st),
        .sup_2v3      (sup_2v3),
        .sup_2v7      (sup_2v7),
        .cpu_pwr_en   (cpu_pwr_en),
        .rf_pwr_en    (rf_pwr_en),
        .wkdet_pwr_en (wkdet_pwr_en),
        .listen_ok    (listen_ok),
        .poll_ok      (poll_ok)
    );

    // Hysteresis: use the upper threshold to stay, the lower one to enter.
    always_comb begin
        bat_low = mon_en && ((st == PS_MON) ? !bat_ok_rise : !bat_ok_fall);
    end

    // Next-state selection in priority order.
    always_comb begin
        nxt = st;
        if (!en_pin) begin
            nxt = PS_OFF;
        end else if (bat_low) begin
            nxt = PS_MON;
        end else begin
            unique case (st)
                PS_OFF, PS_MON: nxt = PS_BOOT;
                PS_BOOT:        nxt = boot_done ? PS_IDLE : PS_BOOT;
                PS_STBY:        nxt = any_wake ? PS_IDLE : PS_STBY;
                PS_IDLE, PS_LSTN, PS_POLL: nxt = pick;
                default:        nxt = PS_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PS_OFF;
        end else begin
            st <= nxt;
        end
    end

    assign state_code = st;
endmodule

// File: rtl/nfc_pwr_ctrl_chk.sv
// Checker for the power state controller: temporal properties over the top
// module's ports, attached by bind below.
module nfc_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_pin,
    input logic       mon_en,
    input logic       bat_ok_rise,
    input logic       bat_ok_fall,
    input logic       stby_en,
    input logic       req_sleep,
    input logic       wk_host,
    input logic       wk_field,
    input logic       lfo_on,
    input logic       sup_2v7,
    input logic [2:0] state_code,
    input logic       cpu_pwr_en,
    input logic       wkdet_pwr_en,
    input logic [2:0] wake_src
);
    a_r2_off_when_en_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_pin |=> state_code == 3'd0);

    a_r3_monitor_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && en_pin && mon_en && !bat_ok_rise) |=> state_code == 3'd1);

    a_r5_standby_domains: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd2 |-> (!cpu_pwr_en && wkdet_pwr_en));

    a_r6_standby_entry_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && $past(state_code) != 3'd2) |-> $past(stby_en && req_sleep));

    a_r8_poller_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd5 |-> $past(sup_2v7));

    a_r10_timer_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && en_pin && !(mon_en && !bat_ok_fall) &&
         !wk_host && !wk_field && !lfo_on) |=> state_code == 3'd2);

    a_r11_host_wake_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && wk_host) |=> wake_src[0]);
endmodule

bind nfc_pwr_ctrl nfc_pwr_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_pin       (en_pin),
    .mon_en       (mon_en),
    .bat_ok_rise  (bat_ok_rise),
    .bat_ok_fall  (bat_ok_fall),
    .stby_en      (stby_en),
    .req_sleep    (req_sleep),
    .wk_host      (wk_host),
    .wk_field     (wk_field),
    .lfo_on       (lfo_on),
    .sup_2v7      (sup_2v7),
    .state_code   (state_code),
    .cpu_pwr_en   (cpu_pwr_en),
    .wkdet_pwr_en (wkdet_pwr_en),
    .wake_src     (wake_src)
);

// File: tb/nfc_pwr_ctrl_bench.sv
// Bench: drives inputs on the falling edge, samples one falling edge later.
module nfc_pwr_ctrl_bench;
    localparam int BOOT_N = 4;

    logic clk = 1'b0;
    logic rst_n, en_pin, mon_en, bat_ok_rise, bat_ok_fall, stby_en;
    logic req_sleep, req_listen, req_poll, wk_host, wk_field, wk_timer;
    logic lfo_on, wake_ack, sup_2v3, sup_2v7;
    logic [2:0] state_code, wake_src;
    logic cpu_pwr_en, rf_pwr_en, wkdet_pwr_en, listen_ok, poll_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nfc_pwr_ctrl #(.BOOT_CYCLES(BOOT_N)) u_nfc_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .mon_en(mon_en),
        .bat_ok_rise(bat_ok_rise), .bat_ok_fall(bat_ok_fall), .stby_en(stby_en),
        .req_sleep(req_sleep), .req_listen(req_listen), .req_poll(req_poll),
        .wk_host(wk_host), .wk_field(wk_field), .wk_timer(wk_timer),
        .lfo_on(lfo_on), .wake_ack(wake_ack), .sup_2v3(sup_2v3), .sup_2v7(sup_2v7),
        .state_code(state_code), .cpu_pwr_en(cpu_pwr_en), .rf_pwr_en(rf_pwr_en),
        .wkdet_pwr_en(wkdet_pwr_en), .listen_ok(listen_ok), .poll_ok(poll_ok),
        .wake_src(wake_src)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; en_pin = 0; mon_en = 0; bat_ok_rise = 0; bat_ok_fall = 0;
        stby_en = 0; req_sleep = 0; req_listen = 0; req_poll = 0;
        wk_host = 0; wk_field = 0; wk_timer = 0; lfo_on = 0; wake_ack = 0;
        sup_2v3 = 0; sup_2v7 = 0;
        repeat (3) tick();
        // R1 reset state
        chk("R1 state", state_code, 0);
        chk("R1 cpu", cpu_pwr_en, 0);
        chk("R1 rf", rf_pwr_en, 0);
        chk("R1 wkdet", wkdet_pwr_en, 0);
        chk("R1 wake_src", wake_src, 0);
        rst_n = 1;
        tick();
        chk("R1 state after release", state_code, 0);

        // R4 boot length
        en_pin = 1; bat_ok_rise = 1; bat_ok_fall = 1; sup_2v3 = 1; sup_2v7 = 1;
        tick();
        chk("R4 boot entered", state_code, 6);
        chk("R12 cpu on in boot", cpu_pwr_en, 1);
        for (int i = 1; i < BOOT_N; i++) begin
            tick();
            chk("R4 still boot", state_code, 6);
        end
        tick();
        chk("R4 idle after boot", state_code, 3);

        // R7 R8 R12 sweep of requests and supply flags
        for (int v = 0; v < 16; v++) begin
            int exp_st;
            req_listen = v[0]; req_poll = v[1]; sup_2v3 = v[2]; sup_2v7 = v[3];
            #1;
            chk("R12 listen_ok", listen_ok, v[2]);
            chk("R12 poll_ok", poll_ok, v[3]);
            exp_st = (v[1] && v[3]) ? 5 : ((v[0] && v[2]) ? 4 : 3);
            tick();
            chk(v[1] ? "R8 sub-mode" : "R7 sub-mode", state_code, exp_st);
            chk("R12 rf enable", rf_pwr_en, (exp_st >= 4) ? 1 : 0);
        end
        req_listen = 0; req_poll = 0; sup_2v3 = 1; sup_2v7 = 1;
        tick();
        chk("R7 back to idle", state_code, 3);

        // R6 standby permission
        req_sleep = 1; stby_en = 0;
        tick(); tick();
        chk("R6 stays idle without permission", state_code, 3);
        stby_en = 1;
        tick();
        chk("R6 standby entered", state_code, 2);
        chk("R5 cpu off", cpu_pwr_en, 0);
        chk("R5 rf off", rf_pwr_en, 0);
        chk("R5 wake detector on", wkdet_pwr_en, 1);
        #1;
        chk("R12 listen_ok low in standby", listen_ok, 0);

        // R9 R10 R11 wake sources; src 3 is the timer with the oscillator off
        for (int s = 0; s < 4; s++) begin
            int exp_bits;
            exp_bits = (s == 3) ? 0 : (1 << ((s > 2) ? 2 : s));
            wk_host = (s == 0); wk_field = (s == 1); wk_timer = (s >= 2);
            lfo_on = (s != 3);
            tick();
            wk_host = 0; wk_field = 0; wk_timer = 0;
            chk((s == 3) ? "R10 timer ignored" : "R9 wake to idle",
                state_code, (s == 3) ? 2 : 3);
            chk((s == 3) ? "R10 no source" : "R11 source captured", wake_src, exp_bits);
            tick();
            chk("R11 source kept", wake_src, exp_bits);
            chk("R6 standby again", state_code, 2);
            wake_ack = 1;
            tick();
            wake_ack = 0;
            chk("R11 ack clears", wake_src, 0);
        end
        // R11 set wins over acknowledge
        wk_field = 1; wake_ack = 1; lfo_on = 0;
        tick();
        wk_field = 0; wake_ack = 0;
        chk("R11 set beats ack", wake_src, 2);
        chk("R9 field wake", state_code, 3);
        wake_ack = 1;
        tick();
        wake_ack = 0;

        // R3 monitor with hysteresis
        req_sleep = 0; mon_en = 1; bat_ok_fall = 0; bat_ok_rise = 0;
        tick();
        chk("R3 monitor entered", state_code, 1);
        chk("R3 cpu off in monitor", cpu_pwr_en, 0);
        bat_ok_fall = 1;
        tick(); tick();
        chk("R3 held inside band", state_code, 1);
        bat_ok_rise = 1;
        tick();
        chk("R3 recovery to boot", state_code, 6);
        repeat (BOOT_N) tick();
        chk("R4 idle after monitor", state_code, 3);
        mon_en = 0; bat_ok_fall = 0; bat_ok_rise = 0;
        tick(); tick();
        chk("R3 monitor disabled", state_code, 3);
        bat_ok_fall = 1; bat_ok_rise = 1;

        // R8 poller fall-back
        req_poll = 1;
        tick();
        chk("R8 poller", state_code, 5);
        sup_2v7 = 0;
        tick();
        chk("R8 fall back on supply loss", state_code, 3);
        req_listen = 1;
        tick();
        chk("R7 listener", state_code, 4);

        // R2 enable pin forces power-down
        en_pin = 0;
        tick();
        chk("R2 power-down", state_code, 0);
        mon_en = 1; bat_ok_fall = 0; bat_ok_rise = 0; wk_host = 1; sup_2v7 = 1;
        tick(); tick();
        chk("R2 held while pin low", state_code, 0);
        chk("R2 cpu off", cpu_pwr_en, 0);
        wk_host = 0; mon_en = 0; bat_ok_fall = 1; bat_ok_rise = 1; en_pin = 1;
        tick();
        chk("R4 boot after pin rises", state_code, 6);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule